// File: doc/BRIEF.md
# 8-bit ALU with Flag Register

This block performs one 8-bit arithmetic, logical or rotate operation per cycle on two operands. The result is available combinationally in the same cycle. Six status bits are derived from that result and its carries: sign, zero, nibble half carry, a shared parity/overflow bit, an operation-kind bit for later decimal correction, and carry. They are packed into one status byte that is written on the clock edge when the caller asks for an update.

An execution pipeline drives the operands, an operation code and a carry input. It reads `result` at once and sees the committed status byte on `flags_q` from the next cycle on. A load path lets a context restore put any value into the status byte directly, and the load wins over an ALU update in the same cycle. The two unused positions of the byte always read as zero.

Operation codes on `op_sel`: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 rotate left through carry, 8 rotate right through carry. Codes 9 to 15 are reserved.

Top module: `alu8_flags`

## Requirements
- R1: Codes 0 and 1 give `result` = (A + B + c) mod 256, where c is `carry_in` for code 1 and 0 for code 0. The carry bit (flag bit 0) is set when the sum exceeds 255.
- R2: Codes 2 and 3 give `result` = (A − B − c) mod 256, where c is `carry_in` for code 3 and 0 for code 2. The carry bit is set when the true difference is negative, which means a borrow occurred.
- R3: After codes 0 to 3, flag bit 2 is set exactly when the signed two's-complement result lies outside −128..+127. For example, 0x78+0x69 gives 0xE1 with flag byte 0x94, and 0xFB+0xF0 gives 0xEB with flag byte 0x81.
- R4: After codes 0 to 3, flag bit 4 is the carry out of bit 3 for additions, and the borrow into bit 4 for subtractions.
- R5: Flag bit 1 is set after codes 2 and 3, and cleared after every other operation that updates the flags.
- R6: Codes 4, 5 and 6 give A AND B, A OR B and A XOR B. After them the carry bit is 0, flag bit 4 is 1 for AND and 0 for OR and XOR, and flag bit 2 is 1 when the result has an even number of ones.
- R7: Code 7 gives {A[6:0], carry_in} with carry = A[7]. Code 8 gives {carry_in, A[7:1]} with carry = A[0]. For both, flag bit 4 is 0 and flag bit 2 is the even-parity bit of the result.
- R8: After any update, flag bit 7 equals result bit 7, flag bit 6 is set when the result is 0x00, and flag bits 5 and 3 are 0.
- R9: `flags_q` changes only on a rising clock edge with `upd_en` or `ld_en` high. Otherwise it holds its value.
- R10: When `ld_en` is high at an edge, `flags_q` takes `ld_val` with bits 5 and 3 cleared, regardless of `upd_en`.
- R11: While `rst_n` is low, `flags_q` is 0x00.
- R12: Codes 9 to 15 pass A to `result` unchanged and leave `flags_q` unchanged even when `upd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| op_sel | input | 4 | Operation code |
| carry_in | input | 1 | Carry or borrow in for codes 1, 3, 7 and 8 |
| upd_en | input | 1 | Commit the ALU status bits at the edge |
| ld_en | input | 1 | Load the status byte from ld_val (has priority) |
| ld_val | input | 8 | Value for a direct load |
| result | output | 8 | Combinational operation result |
| flags_q | output | 8 | Registered status byte S,Z,0,H,0,P/V,N,C from bit 7 down |

## Verification
The assertions assume that `op_sel`, the operands and both enables are known and steady at every rising edge after reset. They also assume that a load and an update may arrive together, with the load taking priority. The bench changes inputs only on falling edges and keeps every control at a defined value from time zero, so the properties are never sampled on X. Its stimulus covers both enables alone and together, both enables low, and reserved codes with `upd_en` high. This exercises the hold, load-priority and reserved-code properties over their full premises.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_RL  = 4'd7,
        OP_RR  = 4'd8
    } alu_op_e;

    // status byte, bit 7 first
    typedef struct packed {
        logic s;
        logic z;
        logic gap5;
        logic h;
        logic gap3;
        logic pv;
        logic n;
        logic c;
    } stat_t;

    localparam logic [7:0] STAT_KEEP_MASK = 8'hD7;
    localparam logic [3:0] OP_LAST        = 4'd8;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
    parameter int DW  = 8,
    parameter int NIB = 4
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          c_flag,
    output logic          h_flag,
    output logic          v_flag
);
    logic [DW-1:0] b_eff;
    logic          c0;
    logic [NIB:0]  lo_sum;
    logic [DW-1:0] seven_sum;
    logic [DW:0]   full_sum;

    always_comb begin
        b_eff     = sub ? ~b : b;
        c0        = sub ? ~cin : cin;
        lo_sum    = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c0};
        seven_sum = {1'b0, a[DW-2:0]} + {1'b0, b_eff[DW-2:0]} + {{(DW-1){1'b0}}, c0};
        full_sum  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c0};
        sum       = full_sum[DW-1:0];
        c_flag    = full_sum[DW] ^ sub;
        h_flag    = lo_sum[NIB] ^ sub;
        v_flag    = seven_sum[DW-1] ^ full_sum[DW];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [3:0]    op,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          c_out
);
    always_comb begin
        res   = a;
        c_out = 1'b0;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_RL: begin
                res   = {a[DW-2:0], cin};
                c_out = a[DW-1];
            end
            OP_RR: begin
                res   = {cin, a[DW-1:1]};
                c_out = a[0];
            end
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NIB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [3:0]    op_sel,
    input  logic          carry_in,
    input  logic          upd_en,
    input  logic          ld_en,
    input  logic [7:0]    ld_val,
    output logic [DW-1:0] result,
    output logic [7:0]    flags_q
);
    typedef struct packed {
        stat_t flags;
    } state_t;

    state_t st_d, st_q;

    logic          is_sub, is_arith, use_cin, op_ok;
    logic [DW-1:0] ar_sum, lg_res;
    logic          ar_c, ar_h, ar_v, lg_c;
    stat_t         alu_stat;

    always_comb begin
        is_sub   = (op_sel == OP_SUB) || (op_sel == OP_SBC);
        is_arith = (op_sel <= OP_SBC);
        use_cin  = (op_sel == OP_ADC) || (op_sel == OP_SBC);
        op_ok    = (op_sel <= OP_LAST);
    end

    alu8_arith #(.DW(DW), .NIB(NIB)) u_arith (
        .a      (opnd_a),
        .b      (opnd_b),
        .sub    (is_sub),
        .cin    (use_cin & carry_in),
        .sum    (ar_sum),
        .c_flag (ar_c),
        .h_flag (ar_h),
        .v_flag (ar_v)
    );

    alu8_logic #(.DW(DW)) u_logic (
        .a     (opnd_a),
        .b     (opnd_b),
        .op    (op_sel),
        .cin   (carry_in),
        .res   (lg_res),
        .c_out (lg_c)
    );

    always_comb begin
        result = is_arith ? ar_sum : lg_res;

        alu_stat      = '0;
        alu_stat.s    = result[DW-1];
        alu_stat.z    = (result == '0);
        alu_stat.gap5 = 1'b0;
        alu_stat.gap3 = 1'b0;
        if (is_arith) begin
            alu_stat.h  = ar_h;
            alu_stat.pv = ar_v;
            alu_stat.n  = is_sub;
            alu_stat.c  = ar_c;
        end else begin
            alu_stat.h  = (op_sel == OP_AND);
            alu_stat.pv = ~^result;
            alu_stat.n  = 1'b0;
            alu_stat.c  = lg_c;
        end

        st_d = st_q;
        if (ld_en) begin
            st_d.flags = stat_t'(ld_val & STAT_KEEP_MASK);
        end else if (upd_en && op_ok) begin
            st_d.flags = alu_stat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flags;

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] op_sel,
    input logic       upd_en,
    input logic       ld_en,
    input logic [7:0] ld_val,
    input logic [7:0] opnd_a,
    input logic [7:0] result,
    input logic [7:0] flags_q
);
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !ld_en) |=> $stable(flags_q));

    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (flags_q == ($past(ld_val) & 8'hD7)));

    a_r12_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'd8 && !ld_en) |=> $stable(flags_q));

    a_r12_reserved_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'd8) |-> (result == opnd_a));

    a_r8_sign_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !ld_en && op_sel <= 4'd8) |=>
        (flags_q[7] == $past(result[7]) && flags_q[6] == ($past(result) == 8'h00)
         && flags_q[5] == 1'b0 && flags_q[3] == 1'b0));

    a_r5_sub_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !ld_en && (op_sel == 4'd2 || op_sel == 4'd3)) |=> flags_q[1]);

    a_r6_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !ld_en && op_sel >= 4'd4 && op_sel <= 4'd6) |=>
        (flags_q[0] == 1'b0 && flags_q[1] == 1'b0));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .upd_en  (upd_en),
    .ld_en   (ld_en),
    .ld_val  (ld_val),
    .opnd_a  (opnd_a),
    .result  (result),
    .flags_q (flags_q)
);

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opnd_a = '0, opnd_b = '0, ld_val = '0;
    logic [3:0] op_sel = '0;
    logic       carry_in = 1'b0, upd_en = 1'b0, ld_en = 1'b0;
    logic [7:0] result, flags_q;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    alu8_flags uut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_sel(op_sel), .carry_in(carry_in), .upd_en(upd_en), .ld_en(ld_en),
        .ld_val(ld_val), .result(result), .flags_q(flags_q)
    );

    // {op, a, b, cin}
    localparam logic [20:0] VEC [14] = '{
        {4'd0, 8'h78, 8'h69, 1'b0},
        {4'd0, 8'hFB, 8'hF0, 1'b0},
        {4'd1, 8'h0F, 8'h00, 1'b1},
        {4'd0, 8'h00, 8'h00, 1'b1},
        {4'd2, 8'h80, 8'h01, 1'b0},
        {4'd2, 8'h00, 8'h01, 1'b1},
        {4'd3, 8'h10, 8'h0F, 1'b1},
        {4'd3, 8'h7F, 8'hFF, 1'b1},
        {4'd4, 8'hF0, 8'h0F, 1'b0},
        {4'd5, 8'h01, 8'h02, 1'b1},
        {4'd6, 8'hFF, 8'h01, 1'b0},
        {4'd7, 8'h80, 8'h00, 1'b0},
        {4'd8, 8'h01, 8'h00, 1'b1},
        {4'd7, 8'h55, 8'h00, 1'b1}
    };

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:       return "R1";
            4'd2, 4'd3:       return "R2";
            4'd4, 4'd5, 4'd6: return "R6";
            4'd7, 4'd8:       return "R7";
            default:          return "R12";
        endcase
    endfunction

    function automatic void model(input logic [3:0] op, input logic [7:0] a, b,
                                  input logic ci, output logic [7:0] r,
                                  output logic [7:0] f);
        int ai, bi, c, t, sa, sb, st;
        logic h, pv, n, cy;
        ai = int'(a); bi = int'(b);
        sa = (ai > 127) ? ai - 256 : ai;
        sb = (bi > 127) ? bi - 256 : bi;
        c  = (op == 4'd1 || op == 4'd3) ? int'(ci) : 0;
        h = 0; pv = 0; n = 0; cy = 0; r = a;
        case (op)
            4'd0, 4'd1: begin
                t = ai + bi + c; r = t[7:0]; cy = (t > 255);
                h = ((ai % 16) + (bi % 16) + c) > 15;
                st = sa + sb + c; pv = (st > 127) || (st < -128);
            end
            4'd2, 4'd3: begin
                t = ai - bi - c; r = t[7:0]; cy = (t < 0);
                h = ((ai % 16) - (bi % 16) - c) < 0;
                st = sa - sb - c; pv = (st > 127) || (st < -128); n = 1;
            end
            4'd4: begin r = a & b; h = 1; end
            4'd5: r = a | b;
            4'd6: r = a ^ b;
            4'd7: begin r = {a[6:0], ci}; cy = a[7]; end
            4'd8: begin r = {ci, a[7:1]}; cy = a[0]; end
            default: ;
        endcase
        if (op >= 4'd4) pv = ~^r;
        f = {r[7], (r == 8'h00), 1'b0, h, 1'b0, pv, n, cy};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [7:0] a, b, input logic ci,
                         input logic upd, input logic ld, input logic [7:0] lv);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; carry_in = ci;
        upd_en = upd; ld_en = ld; ld_val = lv;
        #1;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
        upd_en = 1'b0; ld_en = 1'b0;
        #1;
    endtask

    initial begin
        #(200000 * 8);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] er, ef, prev;
        // R11: reset value
        repeat (2) @(negedge clk);
        #1 chk("R11 reset", flags_q, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // table walk, R8 checked through the full flag byte
        foreach (VEC[i]) begin
            drive(VEC[i][20:17], VEC[i][16:9], VEC[i][8:1], VEC[i][0], 1'b1, 1'b0, 8'h00);
            model(VEC[i][20:17], VEC[i][16:9], VEC[i][8:1], VEC[i][0], er, ef);
            chk({tag_of(VEC[i][20:17]), " result"}, result, er);
            settle();
            chk({tag_of(VEC[i][20:17]), "/R8 flags"}, flags_q, ef);
        end

        // R3 hand examples
        drive(4'd0, 8'h78, 8'h69, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R3 sum", result, 8'hE1);
        settle();
        chk("R3 overflow no carry", flags_q, 8'h94);
        drive(4'd0, 8'hFB, 8'hF0, 1'b0, 1'b1, 1'b0, 8'h00);
        settle();
        chk("R3 carry no overflow", flags_q, 8'h81);

        // R4 half borrow: 0x10-0x01 -> 0x0F, H=1 N=1
        drive(4'd2, 8'h10, 8'h01, 1'b0, 1'b1, 1'b0, 8'h00);
        settle();
        chk("R4 half borrow", flags_q, 8'h12);

        // R5 N cleared by following add
        drive(4'd0, 8'h01, 8'h01, 1'b0, 1'b1, 1'b0, 8'h00);
        settle();
        chk("R5 n cleared", flags_q, 8'h00);

        // R9 hold with no enable
        drive(4'd2, 8'h00, 8'h01, 1'b0, 1'b1, 1'b0, 8'h00);
        settle();
        prev = flags_q;
        drive(4'd4, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
        settle();
        chk("R9 hold", flags_q, prev);

        // R10 load wins over update, gap bits cleared
        drive(4'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 8'hFF);
        settle();
        chk("R10 load priority", flags_q, 8'hD7);
        drive(4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h28);
        settle();
        chk("R10 gap masked", flags_q, 8'h00);

        // R12 reserved codes
        drive(4'd0, 8'h80, 8'h80, 1'b0, 1'b1, 1'b0, 8'h00);
        settle();
        prev = flags_q;
        drive(4'd12, 8'h5A, 8'h33, 1'b1, 1'b1, 1'b0, 8'h00);
        chk("R12 pass a", result, 8'h5A);
        settle();
        chk("R12 flags held", flags_q, prev);
        drive(4'd15, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h00);
        settle();
        chk("R12 code 15 held", flags_q, prev);

        // R11 reset mid-run
        drive(4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'hC5);
        settle();
        rst_n = 1'b0;
        #2 chk("R11 async clear", flags_q, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule